// File: doc/BRIEF.md
# Receive Data Length Tracker

This block keeps the byte count of a received packet that a CPU or DMA engine is draining from a FIFO through a read port. The FIFO has two buffer planes. The receive side reports each arrival as a single pulse that carries the packet length and the target plane. The read port sends one strobe per access, and a width select sets whether that access takes one byte or two. The block keeps a stored length and an occupancy flag for each plane, and it tracks which plane software is reading.

A 13-bit field shows the count that software sees. Its top bit is reserved and always reads zero. In hold-length mode the field shows the full length of the packet being read. In countdown mode it falls with each access. A hold flag can keep a drained packet's length visible until software sends a clear strobe. When double buffering is on, a packet waiting in the other plane becomes current as soon as the current plane empties.

Top module: `rx_len_tracker`

## Requirements
- R1: After reset the whole 13-bit field reads 0. Bit 12 reads 0 at all times.
- R2: With `cnt_mode`=0, the field shows the full length of the current plane from the cycle after its report until the last byte is read. After that it reads 0, provided `hold_en`=0.
- R3: With `cnt_mode`=0 and `hold_en`=1, the field keeps the length after the last byte is read. Further reads do not change it. Only the clear strobe releases it.
- R4: With `cnt_mode`=1, every read strobe on a plane that still holds bytes lowers the field on the next clock edge. The step is 1 when `wide_sel`=0 and 2 when `wide_sel`=1.
- R5: With `cnt_mode`=1, the field reads 0 once the plane is drained. A 2-byte read with one byte left gives 0, not a wrapped value.
- R6: The clear strobe empties the current plane. The field then shows 0, or shows the length waiting in the other plane when double buffering is on.
- R7: With `dbl_en`=1, a length waiting in the other plane appears in the field in the cycle after the current plane drains. It also appears at once if the current plane is already empty.
- R8: With `dbl_en`=0, `rpt_plane` is ignored. A report that arrives while the plane still holds unread data is dropped.
- R9: A report with length 0 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbl_en | input | 1 | Double-buffer mode enable |
| cnt_mode | input | 1 | 0: hold length, 1: count down per read |
| wide_sel | input | 1 | Read port width: 0 byte, 1 two bytes |
| hold_en | input | 1 | Keep a drained length until clear |
| rpt_valid | input | 1 | Receive report pulse |
| rpt_plane | input | 1 | Plane that the report targets |
| rpt_len | input | 12 | Reported length in bytes |
| rd_strobe | input | 1 | One read-port access |
| clr | input | 1 | Buffer-clear strobe |
| len_field | output | 13 | Visible length, bit 12 reserved zero |

## Verification
The bench sweeps every combination of count mode, hold flag and port width over lengths 1 to 9. It checks the field after each read against an arithmetic model. Odd lengths read two bytes at a time expose a design that wraps below zero instead of flooring. Extra reads after the drain, and a clear after the hold, catch a design that lets a held length decay or that never releases it. Double-buffer cases check hand-off on drain, hand-off on clear, and a report that arrives while the current plane is empty. A design that shows the pending plane too early, or that never switches, fails these cases. Single-plane cases show that late or misdirected reports are dropped.

// File: rtl/rxlen_pkg.sv
`timescale 1ns/1ps
package rxlen_pkg;
    parameter int RXLEN_W   = 12;
    parameter int NUM_PLANE = 2;
    typedef logic plane_idx_t;
endpackage

// File: rtl/rxlen_countdown.sv
`timescale 1ns/1ps
module rxlen_countdown #(
    parameter int W = 12
) (
    input  logic [W-1:0] rem_i,
    input  logic         wide_i,
    output logic [W-1:0] rem_o,
    output logic         empty_o
);
    logic [W-1:0] step;

    always_comb begin
        step    = wide_i ? W'(2) : W'(1);
        // floor at zero when the access is wider than what is left
        rem_o   = (rem_i > step) ? (rem_i - step) : '0;
        empty_o = (rem_o == '0);
    end
endmodule

// File: rtl/rxlen_plane_slot.sv
`timescale 1ns/1ps
module rxlen_plane_slot #(
    parameter int W = 12
) (
    input  logic         vld_i,
    input  logic [W-1:0] len_i,
    input  logic         release_i,
    input  logic         hit_i,
    input  logic [W-1:0] new_len_i,
    output logic         vld_o,
    output logic [W-1:0] len_o,
    output logic         accept_o
);
    logic vld_after;

    always_comb begin
        vld_after = vld_i & ~release_i;
        accept_o  = hit_i & ~vld_after & (new_len_i != '0);
        vld_o     = vld_after | accept_o;
        if (accept_o)       len_o = new_len_i;
        else if (vld_after) len_o = len_i;
        else                len_o = '0;
    end
endmodule

// File: rtl/rx_len_tracker.sv
`timescale 1ns/1ps
module rx_len_tracker
    import rxlen_pkg::*;
#(
    parameter int LEN_W = RXLEN_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbl_en,
    input  logic             cnt_mode,
    input  logic             wide_sel,
    input  logic             hold_en,
    input  logic             rpt_valid,
    input  logic             rpt_plane,
    input  logic [LEN_W-1:0] rpt_len,
    input  logic             rd_strobe,
    input  logic             clr,
    output logic [LEN_W:0]   len_field
);
    localparam int NP = NUM_PLANE;

    typedef struct packed {
        plane_idx_t                cur;
        logic [LEN_W-1:0]          rem;
        logic [NP-1:0]             vld;
        logic [NP-1:0][LEN_W-1:0]  len;
    } trk_state_t;

    trk_state_t st_q, st_d;

    logic             cur_vld, rd_ok, drained, keep_len;
    logic [LEN_W-1:0] cd_rem;
    logic             cd_empty;
    plane_idx_t       tgt_plane;
    logic [NP-1:0]             slot_rel, slot_hit, slot_vld, slot_acc;
    logic [NP-1:0][LEN_W-1:0]  slot_len;

    rxlen_countdown #(.W(LEN_W)) u_cd (
        .rem_i   (st_q.rem),
        .wide_i  (wide_sel),
        .rem_o   (cd_rem),
        .empty_o (cd_empty)
    );

    assign cur_vld   = st_q.vld[st_q.cur];
    assign rd_ok     = rd_strobe && cur_vld && (st_q.rem != '0);
    assign drained   = rd_ok && cd_empty;
    assign keep_len  = drained && !cnt_mode && hold_en;
    assign tgt_plane = dbl_en ? rpt_plane : st_q.cur;

    for (genvar gi = 0; gi < NP; gi++) begin : g_plane
        assign slot_rel[gi] = (st_q.cur == plane_idx_t'(gi)) &&
                              ((drained && !keep_len) || clr);
        assign slot_hit[gi] = rpt_valid && (tgt_plane == plane_idx_t'(gi));

        rxlen_plane_slot #(.W(LEN_W)) u_slot (
            .vld_i     (st_q.vld[gi]),
            .len_i     (st_q.len[gi]),
            .release_i (slot_rel[gi]),
            .hit_i     (slot_hit[gi]),
            .new_len_i (rpt_len),
            .vld_o     (slot_vld[gi]),
            .len_o     (slot_len[gi]),
            .accept_o  (slot_acc[gi])
        );
    end

    always_comb begin
        st_d     = st_q;
        st_d.vld = slot_vld;
        st_d.len = slot_len;
        if (rd_ok) st_d.rem = cd_rem;
        if (clr)   st_d.rem = '0;
        if (slot_acc[st_q.cur]) st_d.rem = rpt_len;
        // hand over to the waiting plane once the current one is empty
        if (dbl_en && !slot_vld[st_q.cur] && slot_vld[~st_q.cur]) begin
            st_d.cur = ~st_q.cur;
            st_d.rem = slot_len[~st_q.cur];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        len_field = '0;
        if (cur_vld)
            len_field[LEN_W-1:0] = cnt_mode ? st_q.rem : st_q.len[st_q.cur];
    end
endmodule

// File: rtl/rxlen_tracker_chk.sv
`timescale 1ns/1ps
module rxlen_tracker_chk #(
    parameter int LEN_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dbl_en,
    input logic             cnt_mode,
    input logic             wide_sel,
    input logic             rpt_valid,
    input logic             rd_strobe,
    input logic             clr,
    input logic [LEN_W:0]   len_field
);
    p_rsvd_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        len_field[LEN_W] == 1'b0);

    p_full_len_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!cnt_mode && !clr && !rd_strobe && len_field[LEN_W-1:0] != '0)
        |=> (cnt_mode || len_field == $past(len_field)));

    p_step_size_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode && rd_strobe && !clr && len_field[LEN_W-1:0] > LEN_W'(2))
        |=> (!cnt_mode || len_field[LEN_W-1:0] ==
             $past(len_field[LEN_W-1:0]) - ($past(wide_sel) ? LEN_W'(2) : LEN_W'(1))));

    p_drain_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_mode && rd_strobe && !clr && !dbl_en && !rpt_valid &&
         len_field[LEN_W-1:0] != '0 &&
         len_field[LEN_W-1:0] <= (wide_sel ? LEN_W'(2) : LEN_W'(1)))
        |=> (!cnt_mode || len_field == '0));

    p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !dbl_en && !rpt_valid) |=> (len_field == '0));
endmodule

bind rx_len_tracker rxlen_tracker_chk #(.LEN_W(LEN_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbl_en    (dbl_en),
    .cnt_mode  (cnt_mode),
    .wide_sel  (wide_sel),
    .rpt_valid (rpt_valid),
    .rd_strobe (rd_strobe),
    .clr       (clr),
    .len_field (len_field)
);

// File: tb/rx_len_tracker_bench.sv
`timescale 1ns/1ps
module rx_len_tracker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dbl_en = 1'b0, cnt_mode = 1'b0, wide_sel = 1'b0, hold_en = 1'b0;
    logic        rpt_valid = 1'b0, rpt_plane = 1'b0, rd_strobe = 1'b0, clr = 1'b0;
    logic [11:0] rpt_len = '0;
    logic [12:0] len_field;
    int          n_chk = 0, n_fail = 0;

    always #5 clk = ~clk;

    rx_len_tracker u_rx_len_tracker (
        .clk(clk), .rst_n(rst_n), .dbl_en(dbl_en), .cnt_mode(cnt_mode),
        .wide_sel(wide_sel), .hold_en(hold_en), .rpt_valid(rpt_valid),
        .rpt_plane(rpt_plane), .rpt_len(rpt_len), .rd_strobe(rd_strobe),
        .clr(clr), .len_field(len_field)
    );

    task automatic tick();
        @(posedge clk); #1;
        rpt_valid = 1'b0; rd_strobe = 1'b0; clr = 1'b0;
    endtask

    task automatic check(string req, int exp);
        n_chk++;
        if (len_field !== 13'(exp)) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, len_field, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; tick(); tick();
        check("R1", 0);
        rst_n = 1'b1;
    endtask

    task automatic report(input logic p, input int l);
        rpt_valid = 1'b1; rpt_plane = p; rpt_len = 12'(l); tick();
    endtask

    task automatic rd(input logic w);
        wide_sel = w; rd_strobe = 1'b1; tick();
    endtask

    task automatic do_clr();
        clr = 1'b1; tick();
    endtask

    initial begin
        #2000000;
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1;
        do_reset();
        // sweep: mode x hold x width x length (R2 R3 R4 R5 R6)
        for (int cm = 0; cm < 2; cm++)
        for (int hd = 0; hd < 2; hd++)
        for (int w = 0; w < 2; w++)
        for (int len = 1; len <= 9; len++) begin
            int rem, step, exp;
            cnt_mode = 1'(cm); hold_en = 1'(hd); dbl_en = 1'b0;
            do_reset();
            report(1'b0, len);
            check("R2", len);
            rem = len; step = w + 1;
            for (int k = 0; k < 12 && rem > 0; k++) begin
                rd(1'(w));
                rem = (rem > step) ? rem - step : 0;
                exp = cm ? rem : (rem > 0 ? len : (hd ? len : 0));
                check(cm ? (rem == 0 ? "R5" : "R4") : (rem == 0 && hd ? "R3" : "R2"), exp);
            end
            rd(1'(w));
            check(cm ? "R5" : (hd ? "R3" : "R2"), (cm == 0 && hd) ? len : 0);
            do_clr();
            check("R6", 0);
        end

        // double buffer hand-off on drain (R7)
        for (int cm = 0; cm < 2; cm++) begin
            cnt_mode = 1'(cm); hold_en = 1'b0; dbl_en = 1'b1;
            do_reset();
            report(1'b0, 4); check("R7", 4);
            report(1'b1, 6); check("R7", 4);
            rd(1'b1); check("R4", cm ? 2 : 4);
            rd(1'b1); check("R7", 6);
            rd(1'b1); check("R4", cm ? 4 : 6);
            rd(1'b0); check("R4", cm ? 3 : 6);
            rd(1'b1); check("R4", cm ? 1 : 6);
            rd(1'b1); check("R5", 0);
        end

        // clear with a pending plane (R6)
        cnt_mode = 1'b0; hold_en = 1'b0; dbl_en = 1'b1;
        do_reset();
        report(1'b0, 3); report(1'b1, 8);
        do_clr(); check("R6", 8);

        // report into the other plane while current is empty (R7)
        do_reset();
        report(1'b1, 5); check("R7", 5);

        // held length with a pending plane, then clear (R3 R6)
        hold_en = 1'b1;
        do_reset();
        report(1'b0, 2); report(1'b1, 7);
        rd(1'b1); check("R3", 2);
        rd(1'b1); check("R3", 2);
        do_clr(); check("R6", 7);

        // single plane: late and misdirected reports (R8)
        hold_en = 1'b0; dbl_en = 1'b0; cnt_mode = 1'b0;
        do_reset();
        report(1'b0, 5);
        report(1'b1, 7); check("R8", 5);
        report(1'b0, 9); check("R8", 5);
        rd(1'b1); rd(1'b1); rd(1'b1); check("R8", 0);
        report(1'b1, 6); check("R8", 6);

        // zero-length report (R9)
        do_reset();
        report(1'b0, 0); check("R9", 0);
        report(1'b0, 3); check("R9", 3);

        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule